// File: doc/BRIEF.md
# Oversampled Asynchronous Frame Receiver

This block receives 16-bit converter codes over a single serial line. The line is sampled on a clock that runs at sixteen times the bit rate, and every sample point is placed at a fixed clock count from the start edge of the frame. The line rests high. A frame is a low start bit, then sixteen data bits sent most significant first, then a high stop bit.

When the stop bit is good, the received word is copied into the held output code. When the stop bit is bad, the held code stays as it was, and the block drives a one-clock pulse on its error output. Power-up reset and an asynchronous clear input both force the held code to the bottom-of-span value. Baud-rate generation and the analogue output stage are handled elsewhere.

Top module: `async_frame_rx`

## Requirements
- R1: After reset, code_o equals RESET_CODE (default 16'h0000) and err_o is low.
- R2: A frame is a 0 start bit, then 16 data bits with the MSB first, then a stop bit. When the stop bit is sampled as 1, code_o takes the received word, bit 15 being the first data bit sent.
- R3: Count 0 is the first rising clock edge at which an armed, idle receiver sees rxd_i low. Data bit 15 is sampled at count 24, and each following bit is sampled 16 counts later, so bit 0 is at count 264. The stop bit is sampled at count 280. code_o changes only after the count-280 edge.
- R4: If rxd_i is high at count 8, the start is treated as a glitch. The receiver goes back to idle and does not change code_o or pulse err_o.
- R5: If the stop bit is sampled as 0, code_o keeps its value, and err_o is high for exactly the one clock period after the count-280 edge.
- R6: err_o is low at all other times.
- R7: After a stop sample of 0, no new start is accepted until rxd_i has been seen high. A line held low after a framing error therefore starts no frame.
- R8: While clr_i is high, code_o equals RESET_CODE, and this takes effect without waiting for a clock edge. A clear does not abort a frame that is being received.
- R9: A new start bit may begin straight after a valid stop bit's cell, with no idle time between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock, 16 periods per bit |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| clr_i | input | 1 | Active-high asynchronous clear of the held code |
| rxd_i | input | 1 | Serial data line, idles high |
| code_o | output | 16 | Held converter code |
| err_o | output | 1 | One-clock framing-error pulse, otherwise low |

## Verification
The frame starts when the bench drives the start bit just before a rising edge, and that edge is count 0. The held code must still show its old value at the falling edge before count 280. It must show the new value at the falling edge just after count 280, and err_o is checked high at that same point for bad frames. One falling edge later, err_o must be low again. A falling-edge monitor counts every high err_o cycle, so a pulse that comes too early, too late or too wide shows up as a count mismatch for that frame. Glitch starts and held-low lines are followed by an idle wait and a check of code_o and the pulse count before the next frame. The clear is checked between clock edges, two nanoseconds after clr_i rises.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,  // wait for line high before accepting a start
    ST_IDLE  = 2'd1,  // armed, looking for a low line
    ST_FRAME = 2'd2   // frame in progress
  } rx_state_e;
endpackage

// File: rtl/afr_bit_timer.sv
module afr_bit_timer #(
  parameter int OVS    = 16,
  parameter int DATA_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic chk_o,
  output logic bit_o,
  output logic stop_o
);
  localparam int OVS_LG  = $clog2(OVS);
  localparam int HALF    = OVS / 2;
  localparam int STOP_AT = HALF + OVS * (DATA_W + 1);
  localparam int CNT_W   = $clog2(STOP_AT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mid_cell;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= CNT_W'(1);
    else if (run_i)  cnt_q <= cnt_q + CNT_W'(1);
    else             cnt_q <= '0;
  end

  assign mid_cell = (cnt_q[OVS_LG-1:0] == OVS_LG'(HALF));
  assign chk_o    = run_i && (cnt_q == CNT_W'(HALF));
  assign stop_o   = run_i && (cnt_q == CNT_W'(STOP_AT));
  assign bit_o    = run_i && mid_cell && (cnt_q > CNT_W'(HALF)) && (cnt_q < CNT_W'(STOP_AT));
endmodule

// File: rtl/afr_shift_in.sv
module afr_shift_in #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], bit_i};  // MSB arrives first
  end

  assign word_o = sh_q;
endmodule

// File: rtl/async_frame_rx.sv
module async_frame_rx #(
  parameter int                 DATA_W     = 16,
  parameter int                 OVS        = 16,
  parameter logic [DATA_W-1:0]  RESET_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] code_o,
  output logic              err_o
);
  import afr_pkg::*;

  rx_state_e         state_q, state_d;
  logic              chk_stb, bit_stb, stop_stb;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] code_q;
  logic              err_q;

  afr_bit_timer #(.OVS(OVS), .DATA_W(DATA_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_IDLE && !rxd_i),
    .run_i  (state_q == ST_FRAME),
    .chk_o  (chk_stb),
    .bit_o  (bit_stb),
    .stop_o (stop_stb)
  );

  afr_shift_in #(.W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bit_stb),
    .bit_i  (rxd_i),
    .word_o (word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARM:   if (rxd_i) state_d = ST_IDLE;
      ST_IDLE:  if (!rxd_i) state_d = ST_FRAME;
      ST_FRAME: begin
        if (chk_stb && rxd_i) state_d = ST_IDLE;        // glitch
        else if (stop_stb)    state_d = rxd_i ? ST_IDLE : ST_ARM;
      end
      default:  state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARM;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)                code_q <= RESET_CODE;
    else if (clr_i)             code_q <= RESET_CODE;
    else if (stop_stb && rxd_i) code_q <= word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= stop_stb && !rxd_i;
  end

  assign code_o = code_q;
  assign err_o  = err_q;
endmodule

// File: rtl/async_frame_rx_chk.sv
module async_frame_rx_chk #(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic [DATA_W-1:0]   code_o,
  input logic                err_o,
  input afr_pkg::rx_state_e  state_q,
  input logic                chk_stb,
  input logic                bit_stb,
  input logic                stop_stb
);
  import afr_pkg::*;

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);  // R5
  AST_ERR_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    err_o |-> $stable(code_o));  // R5
  AST_ERR_AFTER_LOW_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> state_q == ST_ARM);  // R6
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chk_stb, bit_stb, stop_stb}));  // R3
  AST_ARM_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ARM |=> state_q != ST_FRAME);  // R7
  AST_CLR_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> code_o == RESET_CODE);  // R8
endmodule

bind async_frame_rx async_frame_rx_chk #(.DATA_W(DATA_W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .code_o   (code_o),
  .err_o    (err_o),
  .state_q  (state_q),
  .chk_stb  (chk_stb),
  .bit_stb  (bit_stb),
  .stop_stb (stop_stb)
);

// File: tb/async_frame_rx_tb.sv
module async_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] code;
  logic        err;

  int          checks = 0;
  int          errors = 0;
  int          err_seen = 0;
  bit          done = 1'b0;
  logic [15:0] exp_code = 16'h0000;

  async_frame_rx u_dut (
    .clk_i (clk), .rst_ni (rst_n), .clr_i (clr), .rxd_i (rxd),
    .code_o (code), .err_o (err)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (err) err_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] old, input logic [15:0] d, input bit stop_b);
    return stop_b ? d : old;
  endfunction

  // call on a falling edge; count 0 is the next rising edge
  task automatic send(input logic [15:0] d, input bit stop_b);
    logic [17:0] cells;
    int e0;
    cells = {1'b0, d, stop_b};
    e0 = err_seen;
    for (int j = 0; j < 17; j++) begin
      rxd = cells[17-j];
      repeat (16) @(negedge clk);
    end
    rxd = stop_b;
    repeat (8) @(negedge clk);
    check(code == exp_code, "R3 code before stop sample", code, exp_code);
    @(negedge clk);
    exp_code = model_next(exp_code, d, stop_b);
    check(code == exp_code, stop_b ? "R2 load on good stop" : "R5 hold on bad stop", code, exp_code);
    check(err == !stop_b, "R5 err after stop sample", err, !stop_b);
    @(negedge clk);
    check(err == 1'b0, "R5 err one cycle wide", err, 0);
    repeat (6) @(negedge clk);
    check(err_seen - e0 == (stop_b ? 0 : 1), "R6 err pulse count", err_seen - e0, stop_b ? 0 : 1);
  endtask

  task automatic glitch(input int g);
    int e0;
    e0 = err_seen;
    rxd = 1'b0;
    repeat (g) @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
    check(code == exp_code, "R4 glitch no update", code, exp_code);
    check(err_seen == e0, "R4 glitch no err", err_seen - e0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0420));
    repeat (3) @(negedge clk);
    check(code == 16'h0000, "R1 reset code", code, 0);
    check(err == 1'b0, "R1 reset err", err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(16'hA5C3, 1'b1);
    send(16'h8000, 1'b1);   // R9 back-to-back, MSB position
    send(16'h0001, 1'b1);   // LSB position
    rxd = 1'b1; repeat (5) @(negedge clk);
    send(16'hFFFF, 1'b1);

    // R7: bad stop, line held low well past a cell, then a good frame
    rxd = 1'b1; repeat (3) @(negedge clk);
    send(16'h1234, 1'b0);
    repeat (40) @(negedge clk);
    check(code == exp_code, "R7 held low no frame", code, exp_code);
    check(err == 1'b0, "R7 held low no err", err, 0);
    rxd = 1'b1; repeat (2) @(negedge clk);
    send(16'h4321, 1'b1);

    for (int g = 1; g < 8; g++) glitch(g);
    send(16'h0F0F, 1'b1);

    // R8 asynchronous clear between edges
    rxd = 1'b1;
    @(negedge clk);
    #3 clr = 1'b1;
    #2 check(code == 16'h0000, "R8 clear without clock", code, 0);
    exp_code = 16'h0000;
    #2 clr = 1'b0;
    @(negedge clk);
    check(code == 16'h0000, "R8 code stays cleared", code, 0);

    for (int n = 0; n < 24; n++) begin
      logic [15:0] d;
      bit          sb;
      int          gap;
      d   = 16'($urandom);
      sb  = ($urandom % 4) != 0;
      gap = $urandom % 12;
      if (!sb && gap == 0) gap = 1;
      send(d, sb);
      rxd = 1'b1;
      repeat (gap) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule